// File: doc/BRIEF.md
# Optical Motion Sensor Transaction Sequencer

This block turns single commands into complete register transactions with an optical motion sensor. It sits above a byte-level serial master that owns the pin timing. The sequencer drives the sensor's active-low chip select itself. It sends the serial master one byte operation at a time and collects the bytes that come back. It runs six operations:

- a register read;
- a register write;
- a resolution update, which is a write to a fixed register;
- a two-byte motion burst;
- a three-register identity check;
- a chip-select resynchronisation pulse.

The byte handshake with the serial master works as follows. `bm_req` is a one-cycle pulse that carries `bm_wr` (1 = send `bm_wdata`, 0 = receive one byte) and `bm_wdata`. The serial master answers with a one-cycle `bm_ack`, and for a receive it presents the byte on `bm_rdata` in that same cycle. The host raises `cmd_valid` with an operation code while `cmd_ready` is high. Exactly one transaction runs at a time, and `done` pulses once when it finishes.

Top module: `optsens_txn_seq`

## Requirements
- R1: After reset, `cs_n` = 1, `cmd_ready` = 1, `done` = 0, `bm_req` = 0, `sig_ok` = 0, and `rd_data`, `dx`, `dy` are zero.
- R2: Op 1 (register write) does the following in order:
  - lowers `cs_n`;
  - sends the address byte `{1'b1, cmd_addr}`;
  - sends `cmd_data`;
  - raises `cs_n` in the cycle after the cycle in which the data byte is acknowledged.
- R3: Op 0 (register read) does the following in order:
  - lowers `cs_n`;
  - sends `{1'b0, cmd_addr}`;
  - receives one byte, which appears on `rd_data`;
  - keeps `cs_n` low for HOLD_CYC further cycles after the acknowledge cycle, then raises it.
- R4: Op 2 (motion burst) does the following in order:
  - sends `{1'b0, BURST_ADDR}`;
  - receives the X byte, then the Y byte;
  - raises `cs_n` in the cycle right after the second acknowledge, with no hold.
- R5: `dx` and `dy` are the burst bytes read as two's-complement numbers and sign-extended to DELTA_W bits.
- R6: Op 5 (resync) holds `cs_n` low for exactly SYNC_CYC cycles and issues no byte operation.
- R7: Op 3 (identity check) reads PID_ADDR, RID_ADDR and PID2_ADDR in that order. Each read is its own chip-select frame, as in R3, with `cs_n` high between frames. `sig_ok` becomes 1 only when the three bytes equal ID_VAL0, ID_VAL1 and ID_VAL2 (default 0x12, 0x01, 0x26) in that order; otherwise it becomes 0.
- R8: Op 4 (resolution) is a register write of `cmd_data` to RES_ADDR, with the same byte sequence as R2.
- R9: Only one transaction runs at a time:
  - `cmd_ready` is low while a transaction runs, and `cmd_valid` is ignored during that time;
  - `bm_req` is raised only while `cs_n` is low;
  - no new `bm_req` is raised before the previous one is acknowledged.
- R10: `done` is high for one cycle at the end of every transaction, and `cs_n` is high in that cycle.
- R11: Op codes 6 and 7 are ignored: `cs_n` does not move and `done` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code (0 read, 1 write, 2 burst, 3 identity, 4 resolution, 5 resync) |
| cmd_addr | input | 7 | Register address for read and write |
| cmd_data | input | 8 | Write or resolution value |
| cmd_ready | output | 1 | Idle, a command is accepted |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Last register read result |
| dx | output | DELTA_W | Signed X motion delta |
| dy | output | DELTA_W | Signed Y motion delta |
| sig_ok | output | 1 | Identity check result |
| cs_n | output | 1 | Sensor chip select, active low |
| bm_req | output | 1 | Byte operation request pulse |
| bm_wr | output | 1 | 1 = send byte, 0 = receive byte |
| bm_wdata | output | 8 | Byte to send |
| bm_ack | input | 1 | Byte operation complete |
| bm_rdata | input | 8 | Received byte, valid with bm_ack |

## Verification
The bench builds the block with the following parameters:
- HOLD_CYC = 5 and SYNC_CYC = 3, so that the exact read hold and resync widths can be counted cycle by cycle, instead of the hundreds of cycles that a one-microsecond setting needs.
- DELTA_W = 10, which enables the sign-extension variant of the delta outputs, so that the upper bits visibly follow bit 7 of each burst byte.

A sensor model answering with varying latency exposes both the per-frame framing of the identity reads and the way the address top bit is encoded.

// File: rtl/optsens_pkg.sv
package optsens_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned REG_AW = 7;

   typedef enum logic [2:0] {
      OP_RDREG  = 3'd0,
      OP_WRREG  = 3'd1,
      OP_MOTION = 3'd2,
      OP_IDENT  = 3'd3,
      OP_SETRES = 3'd4,
      OP_RESYNC = 3'd5
   } seq_op_e;

   localparam logic [2:0] OP_LAST = 3'd5;

   typedef enum logic [1:0] {
      CAP_RD = 2'd0,
      CAP_DX = 2'd1,
      CAP_DY = 2'd2,
      CAP_ID = 2'd3
   } cap_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ISSUE,
      S_WAIT,
      S_HOLD,
      S_GAP,
      S_SYNC,
      S_DONE
   } seq_state_e;

endpackage

// File: rtl/optsens_cycle_timer.sv
module optsens_cycle_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/optsens_frame_ctrl.sv
module optsens_frame_ctrl
   import optsens_pkg::*;
#(
   parameter logic [REG_AW-1:0] BURST_ADDR = 7'h63,
   parameter logic [REG_AW-1:0] PID_ADDR   = 7'h00,
   parameter logic [REG_AW-1:0] RID_ADDR   = 7'h01,
   parameter logic [REG_AW-1:0] PID2_ADDR  = 7'h3E,
   parameter logic [REG_AW-1:0] RES_ADDR   = 7'h19,
   parameter int unsigned       HOLD_CYC   = 200,
   parameter int unsigned       SYNC_CYC   = 200,
   parameter int unsigned       CNT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [REG_AW-1:0] cmd_addr,
   input  logic [BYTE_W-1:0] cmd_data,
   output logic              cmd_ready,
   output logic              done,
   output logic              cs_n,
   output logic              bm_req,
   output logic              bm_wr,
   output logic [BYTE_W-1:0] bm_wdata,
   input  logic              bm_ack,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   input  logic              tmr_zero,
   output logic              cap_en,
   output cap_kind_e         cap_kind,
   output logic [1:0]        cap_idx,
   output logic              id_start
);

   localparam bit              HAS_HOLD = (HOLD_CYC > 0);
   localparam int unsigned     HOLD_M1  = HAS_HOLD ? HOLD_CYC - 1 : 0;
   localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_M1);
   localparam logic [CNT_W-1:0] SYNC_LD = CNT_W'(SYNC_CYC - 1);
   localparam logic [1:0]      LAST_FRAME = 2'd2;

   seq_state_e        state_q, state_n;
   seq_op_e           op_q;
   logic [REG_AW-1:0] addr_q;
   logic [BYTE_W-1:0] data_q;
   logic [1:0]        byte_idx_q;
   logic [1:0]        frame_idx_q;

   logic              accept;
   logic              op_known;
   logic              is_wr_op;
   logic              hold_op;
   logic [1:0]        last_byte;
   logic [REG_AW-1:0] frame_addr;
   seq_state_e        frame_end;
   logic              byte_inc;
   logic              cs_active_n;

   assign op_known = (cmd_op <= OP_LAST);
   assign accept   = (state_q == S_IDLE) && cmd_valid && op_known;
   assign id_start = accept && (seq_op_e'(cmd_op) == OP_IDENT);

   assign is_wr_op  = (op_q == OP_WRREG) || (op_q == OP_SETRES);
   assign hold_op   = HAS_HOLD && ((op_q == OP_RDREG) || (op_q == OP_IDENT));
   assign last_byte = (op_q == OP_MOTION) ? 2'd2 : 2'd1;

   always_comb begin
      case (op_q)
         OP_MOTION: frame_addr = BURST_ADDR;
         OP_SETRES: frame_addr = RES_ADDR;
         OP_IDENT: begin
            case (frame_idx_q)
               2'd0:    frame_addr = PID_ADDR;
               2'd1:    frame_addr = RID_ADDR;
               default: frame_addr = PID2_ADDR;
            endcase
         end
         default:   frame_addr = addr_q;
      endcase
   end

   // first byte of a frame carries the direction in its top bit
   assign bm_req   = (state_q == S_ISSUE);
   assign bm_wr    = (byte_idx_q == 2'd0) || is_wr_op;
   assign bm_wdata = (byte_idx_q == 2'd0) ? {is_wr_op, frame_addr}
                   : (is_wr_op ? data_q : '0);

   assign frame_end = ((op_q == OP_IDENT) && (frame_idx_q != LAST_FRAME)) ? S_GAP : S_DONE;

   always_comb begin
      state_n  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      byte_inc = 1'b0;
      case (state_q)
         S_IDLE: begin
            if (accept) begin
               if (seq_op_e'(cmd_op) == OP_RESYNC) begin
                  state_n  = S_SYNC;
                  tmr_load = 1'b1;
                  tmr_val  = SYNC_LD;
               end else begin
                  state_n = S_ISSUE;
               end
            end
         end
         S_ISSUE: state_n = S_WAIT;
         S_WAIT: begin
            if (bm_ack) begin
               if (byte_idx_q == last_byte) begin
                  if (hold_op) begin
                     state_n  = S_HOLD;
                     tmr_load = 1'b1;
                     tmr_val  = HOLD_LD;
                  end else begin
                     state_n = frame_end;
                  end
               end else begin
                  state_n  = S_ISSUE;
                  byte_inc = 1'b1;
               end
            end
         end
         S_HOLD:  if (tmr_zero) state_n = frame_end;
         S_GAP:   state_n = S_ISSUE;
         S_SYNC:  if (tmr_zero) state_n = S_DONE;
         S_DONE:  state_n = S_IDLE;
         default: state_n = S_IDLE;
      endcase
   end

   assign cs_active_n = !((state_n == S_ISSUE) || (state_n == S_WAIT) ||
                          (state_n == S_HOLD)  || (state_n == S_SYNC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         op_q        <= OP_RDREG;
         addr_q      <= '0;
         data_q      <= '0;
         byte_idx_q  <= '0;
         frame_idx_q <= '0;
         cs_n        <= 1'b1;
      end else begin
         state_q <= state_n;
         cs_n    <= cs_active_n;
         if (accept) begin
            op_q        <= seq_op_e'(cmd_op);
            addr_q      <= cmd_addr;
            data_q      <= cmd_data;
            byte_idx_q  <= '0;
            frame_idx_q <= '0;
         end else if (byte_inc) begin
            byte_idx_q <= byte_idx_q + 1'b1;
         end else if ((state_n == S_GAP) && (state_q != S_GAP)) begin
            byte_idx_q  <= '0;
            frame_idx_q <= frame_idx_q + 1'b1;
         end
      end
   end

   assign cap_en  = (state_q == S_WAIT) && bm_ack && !bm_wr;
   assign cap_idx = frame_idx_q;

   always_comb begin
      case (op_q)
         OP_MOTION: cap_kind = (byte_idx_q == 2'd1) ? CAP_DX : CAP_DY;
         OP_IDENT:  cap_kind = CAP_ID;
         default:   cap_kind = CAP_RD;
      endcase
   end

   assign cmd_ready = (state_q == S_IDLE);
   assign done      = (state_q == S_DONE);

endmodule

// File: rtl/optsens_result_capture.sv
module optsens_result_capture
   import optsens_pkg::*;
#(
   parameter int unsigned       DELTA_W = 8,
   parameter logic [BYTE_W-1:0] ID_VAL0 = 8'h12,
   parameter logic [BYTE_W-1:0] ID_VAL1 = 8'h01,
   parameter logic [BYTE_W-1:0] ID_VAL2 = 8'h26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  cap_kind_e          cap_kind,
   input  logic [1:0]         cap_idx,
   input  logic               id_start,
   input  logic [BYTE_W-1:0]  bm_rdata,
   output logic [BYTE_W-1:0]  rd_data,
   output logic [DELTA_W-1:0] dx,
   output logic [DELTA_W-1:0] dy,
   output logic               sig_ok
);

   localparam int unsigned EXT_W = DELTA_W - BYTE_W;

   logic [BYTE_W-1:0] rd_q, dx_q, dy_q;
   logic              id_acc_q, sig_q;
   logic [BYTE_W-1:0] id_expect;
   logic              id_match;

   always_comb begin
      case (cap_idx)
         2'd0:    id_expect = ID_VAL0;
         2'd1:    id_expect = ID_VAL1;
         default: id_expect = ID_VAL2;
      endcase
   end

   assign id_match = (bm_rdata == id_expect);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= '0;
         dx_q     <= '0;
         dy_q     <= '0;
         id_acc_q <= 1'b0;
         sig_q    <= 1'b0;
      end else begin
         if (id_start) begin
            id_acc_q <= 1'b1;
         end
         if (cap_en) begin
            case (cap_kind)
               CAP_RD: rd_q <= bm_rdata;
               CAP_DX: dx_q <= bm_rdata;
               CAP_DY: dy_q <= bm_rdata;
               CAP_ID: begin
                  if (cap_idx == 2'd2) begin
                     sig_q <= id_acc_q && id_match;
                  end else begin
                     id_acc_q <= id_acc_q && id_match;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_data = rd_q;
   assign sig_ok  = sig_q;

   generate
      if (EXT_W == 0) begin : g_native
         assign dx = dx_q;
         assign dy = dy_q;
      end else begin : g_sext
         assign dx = {{EXT_W{dx_q[BYTE_W-1]}}, dx_q};
         assign dy = {{EXT_W{dy_q[BYTE_W-1]}}, dy_q};
      end
   endgenerate

endmodule

// File: rtl/optsens_txn_seq.sv
module optsens_txn_seq
   import optsens_pkg::*;
#(
   parameter logic [REG_AW-1:0] BURST_ADDR = 7'h63,
   parameter logic [REG_AW-1:0] PID_ADDR   = 7'h00,
   parameter logic [REG_AW-1:0] RID_ADDR   = 7'h01,
   parameter logic [REG_AW-1:0] PID2_ADDR  = 7'h3E,
   parameter logic [REG_AW-1:0] RES_ADDR   = 7'h19,
   parameter logic [BYTE_W-1:0] ID_VAL0    = 8'h12,
   parameter logic [BYTE_W-1:0] ID_VAL1    = 8'h01,
   parameter logic [BYTE_W-1:0] ID_VAL2    = 8'h26,
   parameter int unsigned       HOLD_CYC   = 200,
   parameter int unsigned       SYNC_CYC   = 200,
   parameter int unsigned       DELTA_W    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [6:0]         cmd_addr,
   input  logic [7:0]         cmd_data,
   output logic               cmd_ready,
   output logic               done,
   output logic [7:0]         rd_data,
   output logic [DELTA_W-1:0] dx,
   output logic [DELTA_W-1:0] dy,
   output logic               sig_ok,
   output logic               cs_n,
   output logic               bm_req,
   output logic               bm_wr,
   output logic [7:0]         bm_wdata,
   input  logic               bm_ack,
   input  logic [7:0]         bm_rdata
);

   localparam int unsigned TMAX  = (HOLD_CYC > SYNC_CYC) ? HOLD_CYC : SYNC_CYC;
   localparam int unsigned CNT_W = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

   generate
      if (DELTA_W < BYTE_W) begin : g_bad_delta
         $error("DELTA_W must be at least one byte");
      end
      if (SYNC_CYC < 1) begin : g_bad_sync
         $error("SYNC_CYC must be at least 1");
      end
      if ((PID_ADDR == RID_ADDR) || (RID_ADDR == PID2_ADDR) || (PID_ADDR == PID2_ADDR)) begin : g_bad_id
         $error("identity register addresses must differ");
      end
   endgenerate

   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             cap_en;
   cap_kind_e        cap_kind;
   logic [1:0]       cap_idx;
   logic             id_start;

   optsens_frame_ctrl #(
      .BURST_ADDR (BURST_ADDR),
      .PID_ADDR   (PID_ADDR),
      .RID_ADDR   (RID_ADDR),
      .PID2_ADDR  (PID2_ADDR),
      .RES_ADDR   (RES_ADDR),
      .HOLD_CYC   (HOLD_CYC),
      .SYNC_CYC   (SYNC_CYC),
      .CNT_W      (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .cmd_ready (cmd_ready),
      .done      (done),
      .cs_n      (cs_n),
      .bm_req    (bm_req),
      .bm_wr     (bm_wr),
      .bm_wdata  (bm_wdata),
      .bm_ack    (bm_ack),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .tmr_zero  (tmr_zero),
      .cap_en    (cap_en),
      .cap_kind  (cap_kind),
      .cap_idx   (cap_idx),
      .id_start  (id_start)
   );

   optsens_cycle_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   optsens_result_capture #(
      .DELTA_W (DELTA_W),
      .ID_VAL0 (ID_VAL0),
      .ID_VAL1 (ID_VAL1),
      .ID_VAL2 (ID_VAL2)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_kind (cap_kind),
      .cap_idx  (cap_idx),
      .id_start (id_start),
      .bm_rdata (bm_rdata),
      .rd_data  (rd_data),
      .dx       (dx),
      .dy       (dy),
      .sig_ok   (sig_ok)
   );

endmodule

// File: rtl/optsens_txn_chk.sv
module optsens_txn_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic       cmd_ready,
   input logic       done,
   input logic       cs_n,
   input logic       bm_req,
   input logic       bm_ack
);

   logic pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pending_q <= 1'b0;
      else if (bm_req) pending_q <= 1'b1;
      else if (bm_ack) pending_q <= 1'b0;
   end

   AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> cs_n);                                            // R1
   AST_START_TAKES_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && (cmd_op <= 3'd5)) |=> (!cs_n && !cmd_ready)); // R9
   AST_REQ_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      bm_req |-> !cs_n);                                              // R9
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bm_req |-> !pending_q);                                         // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R10
   AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);                                                 // R10
   AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && (cmd_op > 3'd5)) |=> (cs_n && cmd_ready)); // R11

endmodule

bind optsens_txn_seq optsens_txn_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_ready (cmd_ready),
   .done      (done),
   .cs_n      (cs_n),
   .bm_req    (bm_req),
   .bm_ack    (bm_ack)
);

// File: tb/optsens_txn_seq_tb.sv
`timescale 1ns/1ps
module optsens_txn_seq_tb;

   localparam int HOLD = 5;
   localparam int SYNC = 3;
   localparam int DW   = 10;
   localparam logic [6:0] A_BURST = 7'h63, A_PID = 7'h00, A_RID = 7'h01,
                          A_PID2 = 7'h3E, A_RES = 7'h19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [6:0]    cmd_addr = '0;
   logic [7:0]    cmd_data = '0;
   logic          cmd_ready, done, sig_ok, cs_n, bm_req, bm_wr;
   logic [7:0]    rd_data, bm_wdata;
   logic [DW-1:0] dx, dy;
   logic          bm_ack = 1'b0;
   logic [7:0]    bm_rdata = '0;

   always #2.5 clk = ~clk;

   optsens_txn_seq #(
      .HOLD_CYC (HOLD),
      .SYNC_CYC (SYNC),
      .DELTA_W  (DW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
      .cmd_addr (cmd_addr), .cmd_data (cmd_data), .cmd_ready (cmd_ready),
      .done (done), .rd_data (rd_data), .dx (dx), .dy (dy), .sig_ok (sig_ok),
      .cs_n (cs_n), .bm_req (bm_req), .bm_wr (bm_wr), .bm_wdata (bm_wdata),
      .bm_ack (bm_ack), .bm_rdata (bm_rdata)
   );

   int checks = 0, fails = 0;
   logic [8:0] expq[$];
   string cur_tag = "R9";
   logic [7:0] mem [0:127];
   logic [7:0] bx = '0, by = '0;
   int since_ack = 0, rel_gap = 0, low_cnt = 0, low_len = 0;
   int rise_cnt = 0, fall_cnt = 0, done_cnt = 0;
   logic prev_cs = 1'b1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   task automatic push(input bit wr, input logic [7:0] d);
      expq.push_back({wr, d});
   endtask

   // scoreboard monitor: every byte operation must match the next expected item
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && bm_req) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R9 unexpected byte op", {bm_wr, bm_wdata}, 0);
            end else begin
               logic [8:0] it;
               it = expq.pop_front();
               chk((bm_wr == it[8]) && (!it[8] || bm_wdata == it[7:0]),
                   {cur_tag, " byte op"}, {bm_wr, bm_wdata}, it);
            end
            chk(!cs_n, "R9 cs low at byte op", cs_n, 0);
         end
      end
   end

   // chip-select watcher
   initial begin
      forever begin
         @(negedge clk);
         if (bm_ack) since_ack = 0; else since_ack++;
         if (!cs_n) low_cnt++;
         if (done) done_cnt++;
         if (cs_n && !prev_cs) begin
            rel_gap = since_ack; low_len = low_cnt; low_cnt = 0; rise_cnt++;
         end
         if (!cs_n && prev_cs) fall_cnt++;
         prev_cs = cs_n;
      end
   end

   // sensor behind the serial master
   initial begin
      int pos, nreq, lat;
      logic [6:0] raddr;
      logic wmode;
      logic [7:0] rd;
      pos = 0; nreq = 0; raddr = '0; wmode = 1'b0;
      @(negedge clk);
      forever begin
         if (cs_n) pos = 0;
         if (bm_req) begin
            lat = 1 + (nreq % 3);
            nreq++;
            rd = '0;
            if (pos == 0) begin
               raddr = bm_wdata[6:0]; wmode = bm_wdata[7];
            end else if (bm_wr) begin
               if (wmode) mem[raddr] = bm_wdata;
            end else begin
               rd = (raddr == A_BURST) ? ((pos == 1) ? bx : by) : mem[raddr];
            end
            pos++;
            repeat (lat) @(negedge clk);
            #1;
            bm_ack = 1'b1; bm_rdata = rd;
            @(negedge clk);
            #1;
            bm_ack = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
   end

   task automatic run_cmd(input logic [2:0] op, input logic [6:0] a,
                          input logic [7:0] d, input string tag);
      int n;
      cur_tag = tag;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         chk(1'b0, {tag, " done missing"}, 0, 1);
      end else begin
         #1;
         chk(cs_n == 1'b1, "R10 cs high with done", cs_n, 1);
         chk(expq.size() == 0, {tag, " all byte ops issued"}, expq.size(), 0);
         @(negedge clk);
         chk(!done, "R10 done lasts one cycle", done, 0);
      end
   endtask

   task automatic run_ident(input bit exp_ok);
      int r0;
      r0 = rise_cnt;
      push(1'b1, {1'b0, A_PID});  push(1'b0, 8'h00);
      push(1'b1, {1'b0, A_RID});  push(1'b0, 8'h00);
      push(1'b1, {1'b0, A_PID2}); push(1'b0, 8'h00);
      run_cmd(3'd3, 7'h00, 8'h00, "R7");
      chk(sig_ok == exp_ok, "R7 identity result", sig_ok, exp_ok);
      chk(rise_cnt == r0 + 3, "R7 three separate frames", rise_cnt - r0, 3);
      chk(rel_gap == HOLD, "R7 hold before release", rel_gap, HOLD);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
      mem[A_PID] = 8'h12; mem[A_RID] = 8'h01; mem[A_PID2] = 8'h26;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cs_n && cmd_ready && !done && !bm_req, "R1 control outputs",
          {cs_n, cmd_ready, done, bm_req}, 4'b1100);
      chk(!sig_ok && rd_data == 0 && dx == 0 && dy == 0, "R1 result outputs",
          {sig_ok, rd_data}, 0);

      // R2 register write
      push(1'b1, 8'h85); push(1'b1, 8'hA5);
      run_cmd(3'd1, 7'h05, 8'hA5, "R2");
      chk(mem[5] == 8'hA5, "R2 value stored", mem[5], 8'hA5);
      chk(rel_gap == 0, "R2 release after last byte", rel_gap, 0);

      // R3 register read
      push(1'b1, 8'h05); push(1'b0, 8'h00);
      run_cmd(3'd0, 7'h05, 8'h00, "R3");
      chk(rd_data == 8'hA5, "R3 read data", rd_data, 8'hA5);
      chk(rel_gap == HOLD, "R3 hold cycles", rel_gap, HOLD);
      push(1'b1, 8'h33); push(1'b0, 8'h00);
      run_cmd(3'd0, 7'h33, 8'h00, "R3");
      chk(rd_data == (8'h33 ^ 8'h5A), "R3 second read data", rd_data, 8'h33 ^ 8'h5A);

      // R8 resolution
      push(1'b1, {1'b1, A_RES}); push(1'b1, 8'h40);
      run_cmd(3'd4, 7'h00, 8'h40, "R8");
      chk(mem[A_RES] == 8'h40, "R8 resolution stored", mem[A_RES], 8'h40);

      // R4 / R5 motion burst
      bx = 8'h7F; by = 8'h80;
      push(1'b1, {1'b0, A_BURST}); push(1'b0, 8'h00); push(1'b0, 8'h00);
      run_cmd(3'd2, 7'h00, 8'h00, "R4");
      chk(rel_gap == 0, "R4 early release", rel_gap, 0);
      chk(dx == 10'h07F, "R5 dx positive", dx, 10'h07F);
      chk(dy == 10'h380, "R5 dy negative", dy, 10'h380);
      bx = 8'hFF; by = 8'h01;
      push(1'b1, {1'b0, A_BURST}); push(1'b0, 8'h00); push(1'b0, 8'h00);
      run_cmd(3'd2, 7'h00, 8'h00, "R4");
      chk(dx == 10'h3FF, "R5 dx minus one", dx, 10'h3FF);
      chk(dy == 10'h001, "R4 y byte second", dy, 10'h001);

      // R7 identity
      run_ident(1'b1);
      mem[A_RID] = 8'h02;
      run_ident(1'b0);
      mem[A_RID] = 8'h01; mem[A_PID] = 8'h26; mem[A_PID2] = 8'h12;
      run_ident(1'b0);
      mem[A_PID] = 8'h12; mem[A_PID2] = 8'h26;
      run_ident(1'b1);

      // R6 resync
      run_cmd(3'd5, 7'h00, 8'h00, "R6");
      chk(low_len == SYNC, "R6 low width", low_len, SYNC);

      // R11 reserved codes
      begin
         int f0, d0;
         f0 = fall_cnt; d0 = done_cnt;
         @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd6;
         @(negedge clk); cmd_op = 3'd7;
         @(negedge clk); cmd_valid = 1'b0;
         repeat (8) @(negedge clk);
         chk(fall_cnt == f0, "R11 cs untouched", fall_cnt - f0, 0);
         chk(done_cnt == d0, "R11 no done", done_cnt - d0, 0);
         chk(cmd_ready, "R11 still ready", cmd_ready, 1);
      end

      // R9 commands while busy are ignored
      begin
         int f1;
         push(1'b1, 8'h05); push(1'b0, 8'h00);
         fork
            run_cmd(3'd0, 7'h05, 8'h00, "R9");
            begin
               repeat (3) @(negedge clk);
               chk(!cmd_ready, "R9 busy not ready", cmd_ready, 0);
               cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = 7'h05; cmd_data = 8'h11;
               @(negedge clk);
               cmd_valid = 1'b0;
            end
         join
         f1 = fall_cnt;
         repeat (10) @(negedge clk);
         chk(fall_cnt == f1, "R9 no extra transaction", fall_cnt - f1, 0);
         chk(mem[5] == 8'hA5, "R9 busy write dropped", mem[5], 8'hA5);
         chk(rd_data == 8'hA5, "R9 read completed", rd_data, 8'hA5);
      end

      summary();
      $finish;
   end

endmodule